// File: doc/BRIEF.md
# Zero-Skipping Convolver with Fused Max Pooling and ReLU

This block produces one output feature map of a convolution layer. It takes a stream of signed 8-bit activations and a signed 8-bit weight for each one. Each convolution window adds a 32-bit bias to the sum of its activation-weight products. The block then takes the largest of four consecutive window results, which form one 2×2 pooling group. That maximum is rectified and clipped to the signed 8-bit range, and only this one value per group leaves the block. The producer sends the windows in pooling-group order: top-left, top-right, bottom-left, bottom-right. The block therefore never holds more than one running maximum.

Within a window, activations arrive kernel position by kernel position. At each kernel position all input channels come first, then the next position follows. The index of the current element within its window is driven out as a weight address. The weight store answers combinationally in the same cycle. When an activation is zero, the weight read strobe stays low and the multiply is replaced by a zero contribution. Results for each feature map leave as a stream of single-cycle valid pulses. The last pooled pixel of each map is flagged.

Top module: `conv_pool_core`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, out_valid, out_last and wt_rd are 0.
- R2: For each accepted activation, wt_addr equals its index within the window: kernel position times CH plus channel. The index is 0 for the first activation of every window, and the window ends after CH·KDIM·KDIM accepted activations.
- R3: wt_rd is 1 exactly in cycles where act_valid is 1 and act_data is nonzero. An accepted zero activation leaves the partial sum unchanged.
- R4: A window result equals the bias plus the sum of act_data·wt_data over its elements, both taken as signed. The bias is sampled only with the window's first activation, so a window of all zeros yields exactly that bias.
- R5: Every four consecutive windows form one group. The block emits the group's maximum as a single-cycle out_valid pulse in the cycle after the fourth window's final activation is accepted. out_valid is 0 in every other cycle.
- R6: A group maximum below zero is emitted as 0.
- R7: A group maximum above 127 is emitted as 127. Values from 0 to 127 pass through unchanged.
- R8: out_last is 1 together with every POOL_COLS·POOL_ROWS-th output, and the count then restarts for the next map.
- R9: Cycles with act_valid at 0 change no state: wt_addr holds and later results are as if the idle cycle were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid | input | 1 | Activation present this cycle |
| act_data | input | 8 | Signed activation |
| bias | input | 32 | Signed bias, sampled on a window's first activation |
| wt_addr | output | IDX_W | Index of the current activation within its window |
| wt_rd | output | 1 | Weight read strobe, high only for nonzero activations |
| wt_data | input | 8 | Signed weight for wt_addr, same cycle |
| out_valid | output | 1 | Pooled result valid pulse |
| out_data | output | 8 | Pooled, rectified, clipped result |
| out_last | output | 1 | Final pooled pixel of the map |

## Verification
The bench builds the block with its defaults: two channels and a 3×3 kernel, which gives 18-element windows, and a 2×2 pooled map. With these values a map ends after only four outputs, so the out_last flag and its restart are reached many times within a short run. The bench varies the weight store between maps. Small weights and activations keep many group maxima inside the 0 to 127 pass-through range. Full-range values and large biases drive the rectify and clip branches, and all-zero windows expose the bias path.

// File: rtl/conv_pool_pkg.sv
package conv_pool_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ACC_W  = 32;

  typedef logic signed [DATA_W-1:0] pix_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t PIX_MAX = acc_t'((1 << (DATA_W - 1)) - 1);

  // Product of activation and weight; a zero activation contributes nothing.
  function automatic acc_t gated_product(input pix_t a, input pix_t w);
    acc_t p;
    if (a == '0) p = '0;
    else         p = acc_t'(a) * acc_t'(w);
    return p;
  endfunction

  function automatic acc_t larger(input acc_t x, input acc_t y);
    return (x > y) ? x : y;
  endfunction

  // Rectify, then clip to the positive pixel range.
  function automatic pix_t rectify_clip(input acc_t v);
    pix_t r;
    if (v < 0)             r = '0;
    else if (v > PIX_MAX)  r = pix_t'(PIX_MAX);
    else                   r = pix_t'(v);
    return r;
  endfunction
endpackage

// File: rtl/cp_window_mac.sv
module cp_window_mac
  import conv_pool_pkg::*;
#(
  parameter int CH   = 2,
  parameter int KDIM = 3,
  localparam int WIN_LEN = CH * KDIM * KDIM,
  localparam int IDX_W   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  pix_t             act_data,
  input  pix_t             wt_data,
  input  acc_t             bias,
  output logic [IDX_W-1:0] wt_addr,
  output logic             wt_rd,
  output acc_t             acc_q,
  output logic             win_done,
  output acc_t             win_sum
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  logic [IDX_W-1:0] idx_q;
  logic             act_nz;
  logic             win_first;
  acc_t             base;
  acc_t             prod;

  assign act_nz    = (act_data != '0);
  assign win_first = (idx_q == '0);
  assign wt_addr   = idx_q;
  assign wt_rd     = act_valid & act_nz;
  assign prod      = gated_product(act_data, wt_data);
  assign base      = win_first ? bias : acc_q;
  assign win_sum   = base + prod;
  assign win_done  = act_valid && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (act_valid) begin
      acc_q <= win_sum;
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cp_pool_relu.sv
module cp_pool_relu
  import conv_pool_pkg::*;
#(
  parameter int NPOOL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  input  acc_t win_sum,
  output logic out_valid,
  output pix_t out_data,
  output logic out_last
);
  logic [1:0] grp_pos;
  acc_t       run_max;
  acc_t       grp_max;
  logic       grp_fire;
  logic       map_end;

  assign grp_fire = win_done && (grp_pos == 2'd3);
  assign grp_max  = larger(run_max, win_sum);

  generate
    if (NPOOL > 1) begin : g_cnt
      localparam int CNT_W = $clog2(NPOOL);
      localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(NPOOL - 1);
      logic [CNT_W-1:0] out_cnt;
      assign map_end = (out_cnt == LAST_OUT);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_cnt <= '0;
        else if (grp_fire) out_cnt <= map_end ? '0 : out_cnt + 1'b1;
      end
    end else begin : g_single
      assign map_end = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_pos   <= '0;
      run_max   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= grp_fire;
      out_last  <= grp_fire && map_end;
      if (win_done) begin
        grp_pos <= grp_pos + 1'b1;
        run_max <= (grp_pos == 2'd0) ? win_sum : grp_max;
      end
      if (grp_fire) out_data <= rectify_clip(grp_max);
    end
  end
endmodule

// File: rtl/conv_pool_core.sv
module conv_pool_core
  import conv_pool_pkg::*;
#(
  parameter int CH        = 2,
  parameter int KDIM      = 3,
  parameter int POOL_COLS = 2,
  parameter int POOL_ROWS = 2,
  localparam int WIN_LEN  = CH * KDIM * KDIM,
  localparam int IDX_W    = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act_valid,
  input  logic signed [DATA_W-1:0] act_data,
  input  logic signed [ACC_W-1:0]  bias,
  output logic [IDX_W-1:0]         wt_addr,
  output logic                     wt_rd,
  input  logic signed [DATA_W-1:0] wt_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_last
);
  localparam int NPOOL = POOL_COLS * POOL_ROWS;

  acc_t acc_q;
  acc_t win_sum;
  logic win_done;

  cp_window_mac #(.CH(CH), .KDIM(KDIM)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_valid(act_valid),
    .act_data (act_data),
    .wt_data  (wt_data),
    .bias     (bias),
    .wt_addr  (wt_addr),
    .wt_rd    (wt_rd),
    .acc_q    (acc_q),
    .win_done (win_done),
    .win_sum  (win_sum)
  );

  cp_pool_relu #(.NPOOL(NPOOL)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_done (win_done),
    .win_sum  (win_sum),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last)
  );
endmodule

// File: rtl/conv_pool_chk.sv
module conv_pool_chk
  import conv_pool_pkg::*;
#(
  parameter int WIN_LEN = 18,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act_valid,
  input pix_t             act_data,
  input acc_t             bias,
  input logic [IDX_W-1:0] wt_addr,
  input acc_t             acc_q,
  input logic             out_valid,
  input pix_t             out_data,
  input logic             out_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && wt_addr != LAST_IDX |=> wt_addr == IDX_W'($past(wt_addr) + 1'b1)); // R2
  AST_ZERO_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_data == '0 && wt_addr != '0 |=> $stable(acc_q)); // R3
  AST_ZERO_START_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_data == '0 && wt_addr == '0 |=> acc_q == $past(bias)); // R4
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5
  AST_OUT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[DATA_W-1]); // R6
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> $stable(wt_addr) && $stable(acc_q)); // R9
endmodule

bind conv_pool_core conv_pool_chk #(.WIN_LEN(WIN_LEN), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .act_valid(act_valid),
  .act_data (act_data),
  .bias     (bias),
  .wt_addr  (wt_addr),
  .acc_q    (acc_q),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/tb_conv_pool_core.sv
module tb_conv_pool_core;
  localparam int CH = 2, KDIM = 3, PC = 2, PR = 2;
  localparam int WIN_LEN = CH * KDIM * KDIM;
  localparam int NPOOL = PC * PR;
  localparam int IDX_W = $clog2(WIN_LEN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic act_valid = 1'b0;
  logic signed [7:0] act_data = '0;
  logic signed [31:0] bias = '0;
  logic [IDX_W-1:0] wt_addr;
  logic wt_rd;
  logic signed [7:0] wt_data;
  logic out_valid, out_last;
  logic signed [7:0] out_data;

  int wref [WIN_LEN];
  int win_act [WIN_LEN];
  assign wt_data = (int'(wt_addr) < WIN_LEN) ? 8'(wref[wt_addr]) : 8'sd0;

  conv_pool_core #(.CH(CH), .KDIM(KDIM), .POOL_COLS(PC), .POOL_ROWS(PR)) dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_data(act_data),
    .bias(bias), .wt_addr(wt_addr), .wt_rd(wt_rd), .wt_data(wt_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  int n_chk = 0, n_bad = 0;
  bit mon_on = 0, done = 0;
  int cur_idx = 0;
  bit exp_next_v = 0, exp_now_v = 0, exp_next_l = 0, exp_now_l = 0;
  int exp_next_d = 0, exp_now_d = 0;
  string exp_next_r = "R5", exp_now_r = "R5";
  int grp_sum [4];
  int grp_n = 0, out_seen = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_pix(input int m);
    if (m > 127) return 127;
    if (m < 0) return 0;
    return m;
  endfunction

  // Monitor: mid low phase, after the driver has settled the inputs.
  always @(negedge clk) begin
    #5;
    if (mon_on) begin
      check(wt_rd == (act_valid && act_data != 0), "R3", int'(wt_rd),
            int'(act_valid && act_data != 0));
      if (act_valid) check(int'(wt_addr) == cur_idx, "R2", int'(wt_addr), cur_idx);
      if (exp_now_v) begin
        check(out_valid == 1'b1, "R5", int'(out_valid), 1);
        check(int'(out_data) == exp_now_d, exp_now_r, int'(out_data), exp_now_d);
        check(out_last == exp_now_l, "R8", int'(out_last), int'(exp_now_l));
      end else begin
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
      end
      exp_now_v = exp_next_v; exp_now_d = exp_next_d;
      exp_now_l = exp_next_l; exp_now_r = exp_next_r;
      exp_next_v = 0;
    end
  end

  // Sends win_act as one window; gap_at >= 0 inserts an idle cycle before that element.
  task automatic run_window(input int bv, input int gap_at);
    int s;
    int m;
    s = bv;
    for (int i = 0; i < WIN_LEN; i++) begin
      if (i == gap_at) begin
        @(negedge clk);
        act_valid = 1'b0;
        act_data = 8'sd77;
        bias = 32'(bv + 999);
      end
      @(negedge clk);
      act_valid = 1'b1;
      act_data = 8'(win_act[i]);
      bias = (i == 0) ? 32'(bv) : 32'($urandom);
      cur_idx = i;
      s += win_act[i] * wref[i];
    end
    grp_sum[grp_n] = s;
    grp_n++;
    if (grp_n == 4) begin
      m = grp_sum[0];
      for (int j = 1; j < 4; j++) if (grp_sum[j] > m) m = grp_sum[j];
      exp_next_v = 1;
      exp_next_d = ref_pix(m);
      exp_next_r = (m < 0) ? "R6" : ((m > 127) ? "R7" : "R4");
      exp_next_l = ((out_seen % NPOOL) == NPOOL - 1);
      out_seen++;
      grp_n = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      act_valid = 1'b0;
      act_data = 8'(i + 3);
    end
  endtask

  task automatic fill_acts(input int zero_pct, input int lim);
    for (int i = 0; i < WIN_LEN; i++) begin
      if (int'($urandom % 100) < zero_pct) win_act[i] = 0;
      else win_act[i] = int'($urandom % (2 * lim + 1)) - lim;
    end
  endtask

  task automatic fill_wts(input int lim);
    for (int i = 0; i < WIN_LEN; i++) wref[i] = int'($urandom % (2 * lim + 1)) - lim;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    fill_wts(2);
    repeat (3) @(negedge clk);
    #5;
    check(out_valid == 0 && out_last == 0 && wt_rd == 0, "R1",
          int'(out_valid) + int'(out_last) + int'(wt_rd), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(out_valid == 0 && out_last == 0 && wt_rd == 0, "R1",
          int'(out_valid) + int'(out_last) + int'(wt_rd), 0);
    mon_on = 1;

    // Map 1, group 1: all-zero windows give the bias; max picks 40 (R4, R5).
    for (int i = 0; i < WIN_LEN; i++) win_act[i] = 0;
    run_window(10, -1); run_window(40, -1); run_window(-3, -1); run_window(25, -1);
    idle(2);
    // Group 2: strongly negative sums rectify to 0 (R6).
    for (int g = 0; g < 4; g++) begin fill_acts(20, 127); run_window(-400000 + g, -1); end
    // Group 3: large sums clip to 127 (R7).
    for (int g = 0; g < 4; g++) begin fill_acts(20, 127); run_window(400000 - g, -1); end
    // Group 4: idle gaps inside windows (R9), ends the map (R8).
    for (int g = 0; g < 4; g++) begin fill_acts(30, 20); run_window(int'($urandom % 61) - 30, 3 + g * 4); end
    idle(3);

    // Random maps with small weights: mid-range results.
    for (int mp = 0; mp < 6; mp++) begin
      fill_wts(2);
      for (int g = 0; g < 4 * NPOOL; g++) begin
        fill_acts(35, 24);
        run_window(int'($urandom % 121) - 60, ((g % 3) == 0) ? int'($urandom % WIN_LEN) : -1);
      end
      idle(2);
    end
    // Full-range map.
    fill_wts(127);
    for (int g = 0; g < 4 * NPOOL; g++) begin
      fill_acts(30, 127);
      run_window(int'($urandom % 2001) - 1000, -1);
    end
    idle(4);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule